// File: doc/BRIEF.md
# SD Host Interrupt and Status Register Bank

This block holds the interrupt-related state of an SD host controller. It keeps a raw event register, an interrupt mask, a card-presence status word, a global control word and a status word for the internal DMA engine. It also keeps a few plain configuration words: timeout, block size, byte count, FIFO level and stop-command argument. Ten check-value words are loaded from the card interface logic and can only be read from the bus. The command, DMA and card-detect logic report events through set inputs. The block turns the unmasked events into one registered interrupt line.

Software accesses the bank through a 32-bit port with a write strobe and a combinational read path. Event bits are cleared by writing ones to them. An event that arrives in the same cycle as a clearing write is kept, so no event can be lost between a read and the write that acknowledges it.

Top module: `sdh_irq_regs`

## Requirements
- R1: After reset the register offsets read as follows: 0x00 control = 0x00000300, 0x04 timeout = 0xFFFFFF40, 0x08 block size = 0x00000200, 0x0C byte count = 0x00000200, 0x10 mask = 0, 0x14 pending view = 0, 0x18 raw events = 0, 0x1C card status = 0x00000100, 0x20 FIFO level = 0x000F0000, 0x24 stop argument = 0x0000FFFF, 0x28 DMA status = 0, and the check words at 0x40 + 4*i (i = 0..9) = 0. The interrupt output is low.
- R2: The pending view at 0x14 reads raw AND mask. The interrupt output becomes the OR of that value only while control bit 4 is set, and is low otherwise. The output changes one clock after the state it depends on.
- R3: A full-word write to 0x18 or to 0x14 clears each raw bit that is written as one. A write to 0x1C clears card status bits in the same way.
- R4: A card insert pulse sets raw bit 30, clears raw bit 31 and sets card status bit 8. A card remove pulse sets raw bit 31, clears raw bit 30 and clears status bit 8. If both pulses arrive in the same cycle, the remove pulse wins.
- R5: A write to control stores every bit except bits 2:0, which always read back as zero.
- R6: A write to DMA status at 0x28 clears written-one bits only within bits 9:0. Bits 31:10 do not change on writes. Bits are set from the DMA set input.
- R7: A set pulse on the raw or DMA event input, or a card event, in the same cycle as a write that clears that bit leaves the bit set.
- R8: A write whose strobe is not 4'b1111 changes nothing. Unmapped offsets read as zero, and writes to them have no effect.
- R9: A check word i is loaded from the capture input when the load signal is high. Bus writes to the check-word offsets have no effect.
- R10: Timeout, block size, byte count, mask, FIFO level and stop argument read back the last full-word value written.
- R11: The raw set input cannot change bits 30 and 31. Only card events set those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_strb | input | 4 | Byte strobes; only 4'b1111 is accepted |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| raw_set | input | 32 | Event set pulses into the raw register |
| dma_set | input | 32 | Event set pulses into the DMA status word |
| card_ins | input | 1 | Card inserted pulse |
| card_rem | input | 1 | Card removed pulse |
| chk_load | input | 1 | Load a check word |
| chk_idx | input | 4 | Index of the check word to load |
| chk_val | input | 32 | Check word value |
| irq_o | output | 1 | Registered interrupt line |

## Verification
An event set pulse and a software write that clears the same bit can fall in the same clock edge. The bench drives both at once: a raw or DMA set pulse together with a write-one-to-clear of that bit, and a card insert together with a clear of the card status word. It judges the result by reading back that the bit is still set. It also checks that the interrupt line follows one cycle later, and that it is dropped and restored by control bit 4 independently of the pending view.

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs #(
  parameter int AW   = 8,
  parameter int NCHK = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [3:0]              wr_strb,
  input  logic [AW-1:0]           wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [31:0]             rd_data,
  input  logic [31:0]             raw_set,
  input  logic [31:0]             dma_set,
  input  logic                    card_ins,
  input  logic                    card_rem,
  input  logic                    chk_load,
  input  logic [$clog2(NCHK)-1:0] chk_idx,
  input  logic [31:0]             chk_val,
  output logic                    irq_o
);
  localparam int CIW = $clog2(NCHK);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_TMO  = AW'(8'h04);
  localparam logic [AW-1:0] A_BLK  = AW'(8'h08);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h0C);
  localparam logic [AW-1:0] A_MASK = AW'(8'h10);
  localparam logic [AW-1:0] A_PEND = AW'(8'h14);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h18);
  localparam logic [AW-1:0] A_CARD = AW'(8'h1C);
  localparam logic [AW-1:0] A_LVL  = AW'(8'h20);
  localparam logic [AW-1:0] A_STOP = AW'(8'h24);
  localparam logic [AW-1:0] A_DMA  = AW'(8'h28);
  localparam int            CHK_BASE = 'h40;
  localparam int            CHK_END  = CHK_BASE + 4 * NCHK;
  localparam int            DMA_CLR_W = 10;
  localparam logic [31:0]   CARD_BITS = 32'hC000_0000;
  localparam logic [31:0]   DMA_CLR_MASK = 32'((64'd1 << DMA_CLR_W) - 1);

  logic [31:0] ctrl_q, tmo_q, blk_q, cnt_q, mask_q, raw_q, card_q, lvl_q, stop_q, dma_q;
  logic [31:0] chk_q [NCHK];
  logic        irq_q;
  logic [31:0] raw_nxt, card_nxt, dma_nxt;

  wire         wr_ok   = wr_en && (wr_strb == 4'hF);
  wire [31:0]  raw_clr = (wr_ok && (wr_addr == A_RAW || wr_addr == A_PEND)) ? wr_data : '0;
  wire [31:0]  card_clr = (wr_ok && wr_addr == A_CARD) ? wr_data : '0;
  wire [31:0]  dma_clr = (wr_ok && wr_addr == A_DMA) ? (wr_data & DMA_CLR_MASK) : '0;

  always_comb begin
    raw_nxt  = (raw_q & ~raw_clr) | (raw_set & ~CARD_BITS);
    card_nxt = card_q & ~card_clr;
    if (card_rem) begin
      raw_nxt[31] = 1'b1; raw_nxt[30] = 1'b0; card_nxt[8] = 1'b0;
    end else if (card_ins) begin
      raw_nxt[30] = 1'b1; raw_nxt[31] = 1'b0; card_nxt[8] = 1'b1;
    end
  end

  assign dma_nxt = (dma_q & ~dma_clr) | dma_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 32'h0000_0300;
      tmo_q  <= 32'hFFFF_FF40;
      blk_q  <= 32'h0000_0200;
      cnt_q  <= 32'h0000_0200;
      mask_q <= '0;
      raw_q  <= '0;
      card_q <= 32'h0000_0100;
      lvl_q  <= 32'h000F_0000;
      stop_q <= 32'h0000_FFFF;
      dma_q  <= '0;
      irq_q  <= 1'b0;
      for (int i = 0; i < NCHK; i++) chk_q[i] <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_addr)
          A_CTRL: ctrl_q <= wr_data & ~32'h7;
          A_TMO:  tmo_q  <= wr_data;
          A_BLK:  blk_q  <= wr_data;
          A_CNT:  cnt_q  <= wr_data;
          A_MASK: mask_q <= wr_data;
          A_LVL:  lvl_q  <= wr_data;
          A_STOP: stop_q <= wr_data;
          default: ;
        endcase
      end
      raw_q  <= raw_nxt;
      card_q <= card_nxt;
      dma_q  <= dma_nxt;
      irq_q  <= ctrl_q[4] && |(raw_q & mask_q);
      if (chk_load && int'(chk_idx) < NCHK) chk_q[chk_idx] <= chk_val;
    end
  end

  assign irq_o = irq_q;

  wire [AW-1:0] chk_off = rd_addr - AW'(CHK_BASE);
  wire          chk_hit = (rd_addr[1:0] == 2'b00) && (int'(rd_addr) >= CHK_BASE) &&
                          (int'(rd_addr) < CHK_END);

  always_comb begin
    case (rd_addr)
      A_CTRL: rd_data = ctrl_q;
      A_TMO:  rd_data = tmo_q;
      A_BLK:  rd_data = blk_q;
      A_CNT:  rd_data = cnt_q;
      A_MASK: rd_data = mask_q;
      A_PEND: rd_data = raw_q & mask_q;
      A_RAW:  rd_data = raw_q;
      A_CARD: rd_data = card_q;
      A_LVL:  rd_data = lvl_q;
      A_STOP: rd_data = stop_q;
      A_DMA:  rd_data = dma_q;
      default: rd_data = chk_hit ? chk_q[chk_off[CIW+1:2]] : '0;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |=> !irq_o) else $error("irq while disabled"); // R2
  AST_CTRL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_addr == A_CTRL) |=> (ctrl_q[2:0] == 3'b000)) else $error("ctrl reset bits"); // R5
  AST_CARD_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (card_ins && !card_rem) |=> (raw_q[30] && !raw_q[31] && card_q[8])) else $error("insert"); // R4
  AST_CARD_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
    card_rem |=> (raw_q[31] && !raw_q[30] && !card_q[8])) else $error("remove"); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_set & ~CARD_BITS)) |=> (($past(raw_set) & ~CARD_BITS & ~raw_q) == 32'b0))
    else $error("set lost"); // R7
  AST_DMA_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|dma_set) |=> (dma_q[31:DMA_CLR_W] == $past(dma_q[31:DMA_CLR_W]))) else $error("dma upper"); // R6
  AST_CARD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_q[30] && raw_q[31])) else $error("card flags"); // R11
endmodule

// File: tb/tb_sdh_irq_regs.sv
module tb_sdh_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_strb = 4'h0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] raw_set = '0;
  logic [31:0] dma_set = '0;
  logic        card_ins = 1'b0;
  logic        card_rem = 1'b0;
  logic        chk_load = 1'b0;
  logic [3:0]  chk_idx = '0;
  logic [31:0] chk_val = '0;
  logic        irq_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdh_irq_regs dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic drive(input logic we, input logic [3:0] st, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] rs, input logic [31:0] ds, input logic ci, input logic cr);
    @(negedge clk);
    wr_en = we; wr_strb = st; wr_addr = a; wr_data = d;
    raw_set = rs; dma_set = ds; card_ins = ci; card_rem = cr;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0; raw_set = '0; dma_set = '0; card_ins = 1'b0; card_rem = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, 4'hF, a, d, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", 8'h00, 32'h0000_0300);
    rd_check("R1 tmo", 8'h04, 32'hFFFF_FF40);
    rd_check("R1 blk", 8'h08, 32'h0000_0200);
    rd_check("R1 cnt", 8'h0C, 32'h0000_0200);
    rd_check("R1 mask", 8'h10, 32'h0);
    rd_check("R1 pend", 8'h14, 32'h0);
    rd_check("R1 raw", 8'h18, 32'h0);
    rd_check("R1 card", 8'h1C, 32'h0000_0100);
    rd_check("R1 lvl", 8'h20, 32'h000F_0000);
    rd_check("R1 stop", 8'h24, 32'h0000_FFFF);
    rd_check("R1 dma", 8'h28, 32'h0);
    rd_check("R1 chk0", 8'h40, 32'h0);
    rd_check("R1 chk9", 8'h64, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_plain;
    wr(8'h04, 32'h1234_5678); rd_check("R10 tmo", 8'h04, 32'h1234_5678);
    wr(8'h08, 32'h0000_0040); rd_check("R10 blk", 8'h08, 32'h0000_0040);
    wr(8'h0C, 32'h0000_1000); rd_check("R10 cnt", 8'h0C, 32'h0000_1000);
    wr(8'h20, 32'h0007_0008); rd_check("R10 lvl", 8'h20, 32'h0007_0008);
    wr(8'h24, 32'hA5A5_0001); rd_check("R10 stop", 8'h24, 32'hA5A5_0001);
    wr(8'h10, 32'h0000_0004); rd_check("R10 mask", 8'h10, 32'h0000_0004);
  endtask

  task automatic t_ctrl;
    wr(8'h00, 32'hFFFF_FFFF); rd_check("R5 ctrl all", 8'h00, 32'hFFFF_FFF8);
    wr(8'h00, 32'h0000_0315); rd_check("R5 ctrl mix", 8'h00, 32'h0000_0310);
  endtask

  task automatic t_irq;
    drive(1'b0, 4'h0, 8'h0, 32'h0, 32'h4, '0, 1'b0, 1'b0);
    check("R2 irq latency", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R2 irq up", {31'b0, irq_o}, 32'h1);
    rd_check("R2 pend", 8'h14, 32'h4);
    wr(8'h00, 32'h0000_0300);
    @(negedge clk);
    check("R2 irq gated", {31'b0, irq_o}, 32'h0);
    rd_check("R2 pend kept", 8'h14, 32'h4);
    wr(8'h00, 32'h0000_0310);
    @(negedge clk);
    check("R2 irq restored", {31'b0, irq_o}, 32'h1);
    wr(8'h14, 32'h4);
    rd_check("R3 clear via pend", 8'h18, 32'h0);
    @(negedge clk);
    check("R2 irq drop", {31'b0, irq_o}, 32'h0);
    drive(1'b0, 4'h0, 8'h0, 32'h0, 32'h8, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 masked off irq", {31'b0, irq_o}, 32'h0);
    rd_check("R2 masked pend", 8'h14, 32'h0);
    rd_check("R3 raw bit3", 8'h18, 32'h8);
    wr(8'h18, 32'h8);
    rd_check("R3 clear via raw", 8'h18, 32'h0);
  endtask

  task automatic t_card;
    drive(1'b0, 4'h0, 8'h0, 32'h0, '0, '0, 1'b0, 1'b1);
    rd_check("R4 remove raw", 8'h18, 32'h8000_0000);
    rd_check("R4 remove card", 8'h1C, 32'h0);
    drive(1'b0, 4'h0, 8'h0, 32'h0, '0, '0, 1'b1, 1'b0);
    rd_check("R4 insert raw", 8'h18, 32'h4000_0000);
    rd_check("R4 insert card", 8'h1C, 32'h100);
    drive(1'b0, 4'h0, 8'h0, 32'h0, '0, '0, 1'b1, 1'b1);
    rd_check("R4 both raw", 8'h18, 32'h8000_0000);
    rd_check("R4 both card", 8'h1C, 32'h0);
    drive(1'b0, 4'h0, 8'h0, 32'h0, '0, '0, 1'b1, 1'b0);
    wr(8'h1C, 32'h100);
    rd_check("R3 card clear", 8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_check("R3 raw all clear", 8'h18, 32'h0);
  endtask

  task automatic t_race;
    drive(1'b0, 4'h0, 8'h0, 32'h0, 32'h10, '0, 1'b0, 1'b0);
    drive(1'b1, 4'hF, 8'h18, 32'h10, 32'h10, '0, 1'b0, 1'b0);
    rd_check("R7 raw set wins", 8'h18, 32'h10);
    drive(1'b1, 4'hF, 8'h1C, 32'h100, '0, '0, 1'b1, 1'b0);
    rd_check("R7 insert wins", 8'h1C, 32'h100);
    drive(1'b1, 4'hF, 8'h18, 32'h4000_0000, '0, '0, 1'b1, 1'b0);
    rd_check("R7 insert raw wins", 8'h18, 32'h4000_0010);
    wr(8'h18, 32'hFFFF_FFFF);
    drive(1'b0, 4'h0, 8'h0, 32'h0, 32'hC000_0000, '0, 1'b0, 1'b0);
    rd_check("R11 raw_set blocked", 8'h18, 32'h0);
  endtask

  task automatic t_dma;
    drive(1'b0, 4'h0, 8'h0, 32'h0, '0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd_check("R6 dma set", 8'h28, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_check("R6 dma low field", 8'h28, 32'hFFFF_FC00);
    drive(1'b1, 4'hF, 8'h28, 32'h0000_0103, '0, 32'h0000_0100, 1'b0, 1'b0);
    rd_check("R7 dma set wins", 8'h28, 32'hFFFF_FD00);
  endtask

  task automatic t_access;
    drive(1'b1, 4'h3, 8'h04, 32'h0, '0, '0, 1'b0, 1'b0);
    rd_check("R8 partial strobe", 8'h04, 32'h1234_5678);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_check("R8 unmapped", 8'h2C, 32'h0);
    rd_check("R8 unaligned", 8'h05, 32'h0);
    rd_check("R8 after chk", 8'h68, 32'h0);
  endtask

  task automatic t_chk;
    @(negedge clk); chk_load = 1'b1; chk_idx = 4'd3; chk_val = 32'hDEAD_0003;
    @(negedge clk); chk_idx = 4'd9; chk_val = 32'h0000_0909;
    @(negedge clk); chk_load = 1'b0;
    rd_check("R9 chk3", 8'h4C, 32'hDEAD_0003);
    rd_check("R9 chk9", 8'h64, 32'h0000_0909);
    wr(8'h4C, 32'h1111_1111);
    rd_check("R9 bus write ignored", 8'h4C, 32'hDEAD_0003);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_ctrl();
    t_irq();
    t_card();
    t_race();
    t_dma();
    t_access();
    t_chk();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule